// File: doc/BRIEF.md
# Bidirectional Bus Transfer Register

This block is an eight-stage storage register placed between two 8-bit parallel buses, A and B, with an extra one-bit serial input. Depending on its control inputs it copies a word from either bus into its stages and presents that word on the other bus. It can also gather a serial stream into a parallel word, hold a word by recirculating it, or pass its contents on serially to a further register through a cascade output.

The transfer clock is an ordinary input pin. The block samples it with the fast system clock and acts on its rising edges. Five inputs set the behaviour: the sampled transfer clock, an enable for the A lines, a direction select, a parallel/serial select, and a select that lets parallel loads ignore the transfer clock. Each bus is split into an input vector, an output vector and an output-enable vector. Outside the block, these are merged into real bus lines.

Top module: `bus_xfer_reg`

## Requirements
- R1: A synchronous active-high reset clears all eight stages to zero, so the cascade output and any enabled bus output read zero afterwards.
- R2: With the parallel/serial select high, direction high, A enable high and free-run select low, the A input word is loaded on a detected rising edge of the transfer clock and appears on the B output one system cycle after that edge is sampled. Without an edge the contents do not change.
- R3: With the parallel/serial select high, direction low and free-run select low, the B input word is loaded on a detected rising transfer-clock edge. The A enable has no say in which bus is loaded.
- R4: With the parallel/serial select high and the free-run select high, the selected bus word is loaded on every system cycle whether or not a transfer-clock edge occurs. The selected bus is A when direction is high and A enable is high, and B when direction is low.
- R5: With the parallel/serial select high, direction high and A enable low, the contents are kept unchanged under any transfer-clock activity and under either setting of the free-run select. Bus B keeps showing them.
- R6: With the parallel/serial select low, each detected rising transfer-clock edge shifts the stages. Bit 0 (stage 1) takes the serial input, bit i takes the old bit i-1, and the cascade output equals bit 7 (stage 8).
- R7: With the parallel/serial select low, the free-run select has no effect: without a transfer-clock edge the contents stay unchanged.
- R8: The B output enable is all ones exactly when direction is high, otherwise all zeros. While enabled, the B output equals the stored word; while disabled, it reads zero.
- R9: The A output enable is all ones exactly when A enable is high and direction is low, otherwise all zeros. While enabled, the A output equals the stored word; while disabled, it reads zero. The two buses are never driven at the same time.
- R10: A transfer-clock input held high over several system cycles counts as a single rising edge. Only the first cycle of the high level loads or shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the transfer clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_clk | input | 1 | Transfer clock pin, sampled and edge-detected |
| a_en | input | 1 | Enable for the A lines (input and output) |
| free_run | input | 1 | High: parallel loads occur every system cycle |
| dir_a2b | input | 1 | High: A is source and B is driven; low: the reverse |
| par_sel | input | 1 | High: parallel load; low: serial shift |
| ser_in | input | 1 | Serial data into stage 1 |
| a_in | input | 8 | A bus input word |
| b_in | input | 8 | B bus input word |
| a_out | output | 8 | A bus output word (zero when not driven) |
| a_oe | output | 8 | A bus output enables |
| b_out | output | 8 | B bus output word (zero when not driven) |
| b_oe | output | 8 | B bus output enables |
| ser_out | output | 1 | Stage 8, for cascading |

## Verification
Two things can land in the same system cycle: a free-running parallel load and a rising transfer-clock edge. Likewise a rising edge can coincide with the A enable dropping, which turns the load into recirculation. The sweep runs every combination of the four control inputs against one fixed pattern of transfer-clock levels (rise, hold high, fall, rise again). In that pattern edges coincide with free-run loads, recirculation and serial shifts. The result is judged on the bus outputs and the cascade output against an arithmetic model: exactly one load, shift or hold must happen per cycle, and the edge must never add a second shift or load.

// File: rtl/bxr_pkg.sv
package bxr_pkg;

    localparam int unsigned BXR_WIDTH = 8;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_SHIFT  = 2'd1,
        OP_LOAD_A = 2'd2,
        OP_LOAD_B = 2'd3
    } xfer_op_e;

    typedef struct packed {
        logic a_en;
        logic free_run;
        logic dir_a2b;
        logic par_sel;
    } xfer_ctrl_t;

    // Chooses the stage operation for one system cycle.
    function automatic xfer_op_e pick_op(input xfer_ctrl_t c, input logic rise);
        xfer_op_e op;
        op = OP_HOLD;
        if (c.par_sel) begin
            if (c.free_run || rise) begin
                if (!c.dir_a2b)
                    op = OP_LOAD_B;
                else if (c.a_en)
                    op = OP_LOAD_A;
                else
                    op = OP_HOLD;
            end
        end else if (rise) begin
            op = OP_SHIFT;
        end
        return op;
    endfunction

endpackage

// File: rtl/bxr_edge_detect.sv
module bxr_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    logic pin_q;

    // The previous level keeps tracking during reset so release brings no false edge.
    always_ff @(posedge clk) begin
        pin_q <= pin;
    end

    assign rise = pin & ~pin_q & ~rst;
endmodule

// File: rtl/bxr_steer.sv
module bxr_steer
    import bxr_pkg::*;
(
    input  xfer_ctrl_t ctrl,
    input  logic       rise,
    output xfer_op_e   op
);
    always_comb begin
        op = pick_op(ctrl, rise);
    end
endmodule

// File: rtl/bxr_stages.sv
module bxr_stages
    import bxr_pkg::*;
#(
    parameter int unsigned W = BXR_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  xfer_op_e     op,
    input  logic         ser_in,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] st_q
);
    // Stage 1 is bit 0; a shift moves data toward bit W-1.
    for (genvar i = 0; i < W; i++) begin : g_stage
        logic shift_src;
        logic nxt;

        if (i == 0) begin : g_head
            assign shift_src = ser_in;
        end else begin : g_body
            assign shift_src = st_q[i-1];
        end

        always_comb begin
            unique case (op)
                OP_SHIFT:  nxt = shift_src;
                OP_LOAD_A: nxt = a_in[i];
                OP_LOAD_B: nxt = b_in[i];
                default:   nxt = st_q[i];
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst)
                st_q[i] <= 1'b0;
            else
                st_q[i] <= nxt;
        end
    end
endmodule

// File: rtl/bxr_bus_drive.sv
module bxr_bus_drive
    import bxr_pkg::*;
#(
    parameter int unsigned W = BXR_WIDTH
) (
    input  xfer_ctrl_t   ctrl,
    input  logic [W-1:0] st_q,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    output logic         ser_out
);
    logic drive_a;
    logic drive_b;

    assign drive_b = ctrl.dir_a2b;
    assign drive_a = ctrl.a_en & ~ctrl.dir_a2b;

    assign a_oe    = {W{drive_a}};
    assign b_oe    = {W{drive_b}};
    assign a_out   = drive_a ? st_q : '0;
    assign b_out   = drive_b ? st_q : '0;
    assign ser_out = st_q[W-1];
endmodule

// File: rtl/bus_xfer_reg.sv
module bus_xfer_reg
    import bxr_pkg::*;
#(
    parameter int unsigned W = BXR_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         xfer_clk,
    input  logic         a_en,
    input  logic         free_run,
    input  logic         dir_a2b,
    input  logic         par_sel,
    input  logic         ser_in,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    output logic         ser_out
);
    xfer_ctrl_t   ctrl;
    xfer_op_e     op;
    logic         rise;
    logic [W-1:0] st_q;

    assign ctrl.a_en     = a_en;
    assign ctrl.free_run = free_run;
    assign ctrl.dir_a2b  = dir_a2b;
    assign ctrl.par_sel  = par_sel;

    bxr_edge_detect i_edge (
        .clk  (clk),
        .rst  (rst),
        .pin  (xfer_clk),
        .rise (rise)
    );

    bxr_steer i_steer (
        .ctrl (ctrl),
        .rise (rise),
        .op   (op)
    );

    bxr_stages #(.W(W)) i_stages (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .ser_in (ser_in),
        .a_in   (a_in),
        .b_in   (b_in),
        .st_q   (st_q)
    );

    bxr_bus_drive #(.W(W)) i_drive (
        .ctrl    (ctrl),
        .st_q    (st_q),
        .a_out   (a_out),
        .a_oe    (a_oe),
        .b_out   (b_out),
        .b_oe    (b_oe),
        .ser_out (ser_out)
    );
endmodule

// File: rtl/bus_xfer_reg_chk.sv
module bus_xfer_reg_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         xfer_clk,
    input logic         a_en,
    input logic         free_run,
    input logic         dir_a2b,
    input logic         par_sel,
    input logic         ser_in,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_oe,
    input logic [W-1:0] st_q
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (st_q == '0));

    p_async_load_b_r4: assert property (@(posedge clk) disable iff (rst)
        (par_sel && free_run && !dir_a2b) |=> (st_q == $past(b_in)));

    p_recirc_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (par_sel && dir_a2b && !a_en) |=> $stable(st_q));

    p_shift_step_r6: assert property (@(posedge clk) disable iff (rst)
        (!par_sel && xfer_clk && !$past(xfer_clk))
        |=> (st_q == {$past(st_q[W-2:0]), $past(ser_in)}));

    p_serial_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (!par_sel && !(xfer_clk && !$past(xfer_clk))) |=> $stable(st_q));

    p_one_bus_driven_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({a_oe[0], b_oe[0]}));
endmodule

bind bus_xfer_reg bus_xfer_reg_chk #(.W(W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .xfer_clk (xfer_clk),
    .a_en     (a_en),
    .free_run (free_run),
    .dir_a2b  (dir_a2b),
    .par_sel  (par_sel),
    .ser_in   (ser_in),
    .a_in     (a_in),
    .b_in     (b_in),
    .a_oe     (a_oe),
    .b_oe     (b_oe),
    .st_q     (st_q)
);

// File: tb/test_bus_xfer_reg.sv
`timescale 1ns/1ps
module test_bus_xfer_reg;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         xfer_clk = 1'b0;
    logic         a_en = 1'b0;
    logic         free_run = 1'b0;
    logic         dir_a2b = 1'b0;
    logic         par_sel = 1'b0;
    logic         ser_in = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    logic         ser_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [W-1:0] exp_st = '0;
    logic         prev_pin = 1'b0;

    always #2 clk = ~clk;

    bus_xfer_reg #(.W(W)) i_bus_xfer_reg (
        .clk(clk), .rst(rst), .xfer_clk(xfer_clk), .a_en(a_en),
        .free_run(free_run), .dir_a2b(dir_a2b), .par_sel(par_sel),
        .ser_in(ser_in), .a_in(a_in), .b_in(b_in), .a_out(a_out),
        .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe), .ser_out(ser_out)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    // Model update for one system cycle, from the requirement rules.
    task automatic model_step(output string tag);
        logic edge_now;
        edge_now = xfer_clk & ~prev_pin;
        tag = "R7";
        if (rst) begin
            exp_st = '0;
            tag = "R1";
        end else if (par_sel) begin
            if (dir_a2b && !a_en) tag = "R5";
            else if (free_run) tag = "R4";
            else if (dir_a2b) tag = "R2";
            else tag = "R3";
            if (free_run || edge_now) begin
                if (!dir_a2b) exp_st = b_in;
                else if (a_en) exp_st = a_in;
            end
        end else begin
            if (edge_now) begin
                exp_st = {exp_st[W-2:0], ser_in};
                tag = "R6";
            end else if (xfer_clk) begin
                tag = "R10";
            end
        end
        prev_pin = xfer_clk;
    endtask

    task automatic check_outputs(input string tag);
        logic [W-1:0] e_aoe, e_boe;
        e_boe = {W{dir_a2b}};
        e_aoe = {W{a_en & ~dir_a2b}};
        check("R8", "b_oe", b_oe, e_boe);
        check("R9", "a_oe", a_oe, e_aoe);
        check(tag, "b_out", b_out, dir_a2b ? exp_st : '0);
        check(tag, "a_out", a_out, (a_en & ~dir_a2b) ? exp_st : '0);
        check(tag, "ser_out", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, exp_st[W-1]});
    endtask

    task automatic cycle();
        string tag;
        @(posedge clk);
        #1;
        model_step(tag);
        check_outputs(tag);
    endtask

    initial begin
        // Reset with a word that differs from zero on the B side first.
        repeat (3) begin
            @(negedge clk);
            dir_a2b = 1'b1;
            a_in = 8'hFF;
            cycle();
        end
        @(negedge clk);
        rst = 1'b0;
        prev_pin = xfer_clk;
        // Sweep every control combination against a fixed pin pattern.
        for (int c = 0; c < 16; c++) begin
            for (int k = 0; k < 7; k++) begin
                @(negedge clk);
                a_en     = c[0];
                free_run = c[1];
                dir_a2b  = c[2];
                par_sel  = c[3];
                // Rise at k=1, held through k=3 (R10), fall, rise again at k=5.
                xfer_clk = (k == 1) || (k == 2) || (k == 3) || (k == 5);
                ser_in   = ((k + c) % 3) != 0;
                a_in     = 8'((c * 29 + k * 53 + 7) % 256);
                b_in     = 8'((c * 71 + k * 13 + 150) % 256);
                cycle();
            end
        end
        // Fill with a known word, then a mid-run reset must clear it (R1).
        @(negedge clk);
        par_sel = 1'b1; free_run = 1'b1; dir_a2b = 1'b0; a_en = 1'b1;
        b_in = 8'hC3; xfer_clk = 1'b0;
        cycle();
        @(negedge clk);
        rst = 1'b1; b_in = 8'h3C;
        cycle();
        @(negedge clk);
        rst = 1'b0; free_run = 1'b0;
        cycle();
        // Serial fill of eight ones, driven by edges only (R6).
        for (int s = 0; s < 16; s++) begin
            @(negedge clk);
            par_sel = 1'b0; dir_a2b = 1'b1; ser_in = 1'b1; free_run = 1'b1;
            xfer_clk = s[0];
            cycle();
        end
        done = 1'b1;
        finish_run();
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end
endmodule